// File: doc/BRIEF.md
# Page-mode DRAM read output controller

This block models how one DRAM device drives or floats its read data pins. A sampling clock watches the active-low row strobe, column strobe, output enable and write enable. A CAS falling edge in a read cycle (RAS low, WE high) captures a word from the array into an output latch. From then on the block decides on every clock whether the latch drives the bus or floats it.

A mode input selects one of two output behaviours:

- **Fast-page:** the word is dropped as soon as CAS is seen high.
- **Extended-data-out:** the word stays on the bus after CAS rises, so the controller can overlap CAS precharge with data capture.

In that held phase, an OE change or a WE low pulse ends the drive for good. Once both strobes are high, a clocked turn-off count ends it. A later CAS fall reloads the latch.

The block is meant for controller-side behavioural models and for verification environments that need a cycle-accurate picture of when a bus contention window opens or closes.

Top module: `edoDataOut`

## Requirements
- R1: After reset `dqOe` is 0 and `dqOut` is all zeros.
- R2: A clock that samples CAS low, having sampled it high on the previous clock, loads `arrayData` into the latch if RAS is low and WE is high. The word appears on `dqOut` after that edge, and later changes of `arrayData` do not alter `dqOut`.
- R3: With `edoMode` = 0 (fast-page), any clock that samples CAS high makes `dqOe` 0 after that edge.
- R4: With `edoMode` = 1, a loaded word keeps `dqOe` = 1 and `dqOut` unchanged after CAS rises, while RAS and OE stay low.
- R5: OE high while RAS and CAS are low gives `dqOe` = 0. When OE returns low, the same word drives again.
- R6: A clock that samples a change of OE while CAS is high floats the outputs. They stay floating even after OE returns low, until the next read CAS fall.
- R7: A clock that samples WE low while CAS is high floats the outputs. They stay floating after WE returns high.
- R8: The drive ends when `OFF_CYC` consecutive clocks (default 3) sample both RAS and CAS high. `dqOe` is 0 after the `OFF_CYC`-th such clock and is unaffected by the earlier ones.
- R9: A CAS fall sampled while RAS is high loads nothing: `dqOut` keeps its value and a floating bus stays floating.
- R10: A new read CAS fall with OE low, after the outputs have floated, loads the fresh word and sets `dqOe` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| edoMode | input | 1 | 1 = extended-data-out hold, 0 = fast-page |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| arrayData | input | DATA_W | Read word from the array |
| dqOut | output | DATA_W | Output latch value |
| dqOe | output | 1 | Tri-state driver enable, 1 = driving |

## Verification
The hardest state to reach is the extended-data-out hold phase: CAS already high, RAS still low, the bus still driven. Only that phase lets the OE-toggle and WE-pulse kill rules be told apart from a plain CAS float.

The stimulus reaches it by loading a word with a full read cycle in EDO mode and then raising CAS alone. It then confirms the bus is still driven before applying the OE or WE disturbance.

The turn-off count is reached by raising both strobes together from that phase. The bench then samples on each of the following clocks to pin down the exact edge where the drive ends.

// File: rtl/edo_out_pkg.sv
package edo_out_pkg;

  // Strobes from the control to the datapath, one set per sampling clock.
  typedef struct packed {
    logic load;   // capture the array word into the output latch
    logic drive;  // registered tri-state enable for the next cycle
  } outStrobe_t;

endpackage

// File: rtl/edoOutCtrl.sv
module edoOutCtrl
  import edo_out_pkg::*;
#(
  parameter int OFF_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       edoMode,
  input  logic       rasN,
  input  logic       casN,
  input  logic       oeN,
  input  logic       weN,
  output outStrobe_t stb
);

  localparam int CNT_W = (OFF_CYC < 2) ? 1 : $clog2(OFF_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OFF_CYC - 1);

  logic             casQ;
  logic             oeQ;
  logic             armed;
  logic [CNT_W-1:0] offCnt;

  logic casFall;
  logic bothHigh;
  logic loadNow;
  logic offDone;
  logic oeMoved;
  logic armedNext;

  always_comb begin
    casFall   = casQ & ~casN;
    bothHigh  = rasN & casN;
    loadNow   = casFall & ~rasN & weN;
    offDone   = bothHigh & (offCnt == LAST_CNT);
    oeMoved   = oeN ^ oeQ;
    armedNext = armed;
    if (loadNow) begin
      armedNext = 1'b1;
    end else if (armed) begin
      if (!edoMode && casN)       armedNext = 1'b0; // fast-page float
      else if (casN && oeMoved)   armedNext = 1'b0; // OE change after CAS rise
      else if (casN && !weN)      armedNext = 1'b0; // WE pulse in CAS high time
      else if (offDone)           armedNext = 1'b0; // turn-off count expired
    end
    stb.load  = loadNow;
    stb.drive = armedNext & ~oeN & weN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      casQ   <= 1'b1;
      oeQ    <= 1'b1;
      armed  <= 1'b0;
      offCnt <= '0;
    end else begin
      casQ  <= casN;
      oeQ   <= oeN;
      armed <= armedNext;
      if (!bothHigh)              offCnt <= '0;
      else if (offCnt != LAST_CNT) offCnt <= offCnt + 1'b1;
    end
  end

endmodule

// File: rtl/edoOutPath.sv
module edoOutPath
  import edo_out_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  outStrobe_t        stb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqOut <= '0;
      dqOe  <= 1'b0;
    end else begin
      if (stb.load) dqOut <= arrayData;
      dqOe <= stb.drive;
    end
  end

endmodule

// File: rtl/edoDataOut.sv
module edoDataOut
  import edo_out_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int OFF_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              edoMode,
  input  logic              rasN,
  input  logic              casN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  outStrobe_t stb;

  edoOutCtrl #(.OFF_CYC(OFF_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .edoMode(edoMode),
    .rasN(rasN), .casN(casN), .oeN(oeN), .weN(weN),
    .stb(stb)
  );

  edoOutPath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .arrayData(arrayData), .dqOut(dqOut), .dqOe(dqOe)
  );

endmodule

// File: rtl/edoDataOutChk.sv
module edoDataOutChk #(
  parameter int DATA_W  = 16,
  parameter int OFF_CYC = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              edoMode,
  input logic              rasN,
  input logic              casN,
  input logic              oeN,
  input logic              weN,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] dqOut,
  input logic              dqOe
);

  // Counts consecutive samples with both strobes high, saturating.
  int highRun;
  always_ff @(posedge clk) begin
    if (!rstN)              highRun <= 0;
    else if (!(rasN && casN)) highRun <= 0;
    else if (highRun < OFF_CYC) highRun <= highRun + 1;
  end

  // R1
  a_r1_reset_float: assert property (@(posedge clk) !rstN |=> !dqOe);

  // R2
  a_r2_load_word: assert property (@(posedge clk) disable iff (!rstN)
    ($past(casN) && !casN && !rasN && weN) |=> (dqOut == $past(arrayData)));

  // R3
  a_r3_fpm_float: assert property (@(posedge clk) disable iff (!rstN)
    (!edoMode && casN) |=> !dqOe);

  // R5
  a_r5_oe_high_float: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> !dqOe);

  // R6
  a_r6_oe_move_kill: assert property (@(posedge clk) disable iff (!rstN)
    (casN && (oeN != $past(oeN))) |=> !dqOe);

  // R7
  a_r7_we_kill: assert property (@(posedge clk) disable iff (!rstN)
    (casN && !weN) |=> !dqOe);

  // R8
  a_r8_turn_off: assert property (@(posedge clk) disable iff (!rstN)
    (highRun >= OFF_CYC) |-> !dqOe);

endmodule

bind edoDataOut edoDataOutChk #(.DATA_W(DATA_W), .OFF_CYC(OFF_CYC)) uChk (
  .clk(clk), .rstN(rstN), .edoMode(edoMode), .rasN(rasN), .casN(casN),
  .oeN(oeN), .weN(weN), .arrayData(arrayData), .dqOut(dqOut), .dqOe(dqOe)
);

// File: tb/tb_edoDataOut.sv
`timescale 1ns/1ps
module tb_edoDataOut;

  localparam int DATA_W  = 16;
  localparam int OFF_CYC = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              edoMode = 1'b1;
  logic              rasN = 1'b1;
  logic              casN = 1'b1;
  logic              oeN = 1'b0;
  logic              weN = 1'b1;
  logic [DATA_W-1:0] arrayData = '0;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  edoDataOut #(.DATA_W(DATA_W), .OFF_CYC(OFF_CYC)) dut (
    .clk(clk), .rstN(rstN), .edoMode(edoMode), .rasN(rasN), .casN(casN),
    .oeN(oeN), .weN(weN), .arrayData(arrayData), .dqOut(dqOut), .dqOe(dqOe)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rasN = 1'b1; casN = 1'b1; oeN = 1'b0; weN = 1'b1;
    repeat (OFF_CYC + 2) step();
  endtask

  // Full read cycle start: RAS low, then CAS low loads w.
  task automatic readLoad(input logic [DATA_W-1:0] w);
    rasN = 1'b0; step();
    arrayData = w; casN = 1'b0; step();
  endtask

  task automatic tReset();
    chk("R1 dqOe", dqOe, '0);
    chk("R1 dqOut", dqOut, '0);
  endtask

  task automatic tFastPage();
    edoMode = 1'b0;
    readLoad(16'hA5A5);
    chk("R2 dqOut load", dqOut, 16'hA5A5);
    chk("R2 dqOe load", dqOe, 1);
    arrayData = 16'h1111; step();
    chk("R2 latch held", dqOut, 16'hA5A5);
    casN = 1'b1; step();
    chk("R3 fpm float", dqOe, 0);
    idle();
    edoMode = 1'b1;
  endtask

  task automatic tEdoHoldAndOe();
    readLoad(16'h3C3C);
    casN = 1'b1; step();
    chk("R4 edo drive", dqOe, 1);
    chk("R4 edo data", dqOut, 16'h3C3C);
    step();
    chk("R4 edo drive 2", dqOe, 1);
    oeN = 1'b1; step();
    chk("R6 oe rise float", dqOe, 0);
    oeN = 1'b0; step();
    chk("R6 stays float", dqOe, 0);
    arrayData = 16'h7E7E; casN = 1'b0; step();
    chk("R10 reload drive", dqOe, 1);
    chk("R10 reload data", dqOut, 16'h7E7E);
    idle();
  endtask

  task automatic tOePulse();
    readLoad(16'h1234);
    arrayData = 16'h0000;
    oeN = 1'b1; step();
    chk("R5 oe high float", dqOe, 0);
    oeN = 1'b0; step();
    chk("R5 redrive", dqOe, 1);
    chk("R5 same word", dqOut, 16'h1234);
    idle();
  endtask

  task automatic tWeKill();
    readLoad(16'h4321);
    casN = 1'b1; step();
    chk("R7 pre drive", dqOe, 1);
    weN = 1'b0; step();
    chk("R7 we float", dqOe, 0);
    weN = 1'b1; step();
    chk("R7 stays float", dqOe, 0);
    idle();
  endtask

  task automatic tTurnOff();
    readLoad(16'h0F0F);
    rasN = 1'b1; casN = 1'b1;
    for (int i = 1; i < OFF_CYC; i++) begin
      step();
      chk("R8 still driving", dqOe, 1);
    end
    step();
    chk("R8 turned off", dqOe, 0);
    chk("R8 data kept", dqOut, 16'h0F0F);
  endtask

  task automatic tNoLoad();
    arrayData = 16'hBEEF;
    rasN = 1'b1; casN = 1'b0; step();
    chk("R9 no load data", dqOut, 16'h0F0F);
    chk("R9 no drive", dqOe, 0);
    idle();
  endtask

  initial begin
    repeat (3) step();
    tReset();
    rstN = 1'b1; step();
    tFastPage();
    tEdoHoldAndOe();
    tOePulse();
    tWeKill();
    tTurnOff();
    tNoLoad();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule